// File: doc/BRIEF.md
# Self-Timed Page Programming Controller

This block sits between a serial command decoder and a nonvolatile storage array. The decoder first opens a write command, giving its kind and start address. It then hands over the received data words one at a time. Finally it reports when chip select drops. If chip select drops exactly on a word boundary and every buffered word targets a writable location, the controller starts a self-timed programming cycle. During that cycle it reports busy to the outside. When a cycle counter expires, the controller commits the buffered words to the array, one word per clock.

There are three command kinds. A single write stores one word. A page write stores up to a page of words; the low address bits advance and wrap inside the page. A fill writes one value to every location of the array. The protection decision belongs to the surrounding logic. The controller shows that logic the address of the word about to arrive and records the hit answer it returns. One hit anywhere in the command cancels the whole command. The cycle length is a parameter in system clocks, so a test can use a short cycle while silicon uses milliseconds.

Top module: `pgm_cycle_ctrl`

## Requirements
- R1: In a page write, word k (counting from 0) goes to the address whose upper bits equal those of `cmd_addr` and whose low log2(PAGE_WORDS) bits equal (`cmd_addr` low bits + k) modulo PAGE_WORDS.
- R2: A cycle starts only when `cs_fall` arrives with `cs_fall_aligned` high and at least one word has been accepted. Any other `cs_fall` during collection drops the command, and nothing is written.
- R3: `chk_addr` presents the address of the next word to be received; for a fill it presents 0. If `chk_hit` is high when any accepted word arrives, the whole command is dropped at `cs_fall`.
- R4: A fill writes the single received word to every one of the 2^ADDR_W locations, in ascending address order.
- R5: `busy` rises in the clock after an accepted `cs_fall`. It stays high for exactly CYC_LEN + N clocks, where N is the number of words committed, and `arr_we` is high in the last N of those clocks.
- R6: `cmd_kind` encodes the command: 0 is a single write, 1 a page write, 2 a fill, 3 is ignored. Words beyond the limit of the kind (PAGE_WORDS for a page write, 1 otherwise) are ignored.
- R7: The buffered words are committed in the order in which they were received.
- R8: `done` is high for one clock, the clock after the last `arr_we`, and only for a cycle that was started.
- R9: While `busy` is high, `cmd_open`, `word_vld` and `cs_fall` have no effect.
- R10: After reset, `busy`, `arr_we` and `done` are low.
- R11: A `cmd_open` during collection discards the words collected so far and starts a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_open | input | 1 | Opens a write command (one-clock pulse) |
| cmd_kind | input | 2 | Command kind: 0 single, 1 page, 2 fill |
| cmd_addr | input | ADDR_W | Start address of the command |
| word_vld | input | 1 | One received data word is on `word_data` |
| word_data | input | DATA_W | Received data word |
| cs_fall | input | 1 | Chip select has dropped |
| cs_fall_aligned | input | 1 | The drop came right after the last bit of a word |
| chk_addr | output | ADDR_W | Address to be checked for protection |
| chk_hit | input | 1 | `chk_addr` lies in the protected area |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| done | output | 1 | Cycle finished, all words committed |

## Verification
The bench builds the controller with a 4-bit address (16 locations), 8-bit data, 4-word pages and a 6-clock cycle. With that configuration it can sweep every start address and every word count from 1 to 4 against three protection limits. Every in-page wrap and every partial overlap with the protected area gets covered that way. The small array also makes it cheap to run a complete fill and compare the entire array contents after every command. The short cycle lets commands issued during busy land well inside the cycle window.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
   typedef enum logic [1:0] {
      WK_SINGLE = 2'd0,
      WK_PAGE   = 2'd1,
      WK_FILL   = 2'd2,
      WK_NONE   = 2'd3
   } wr_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COLLECT = 2'd1,
      ST_TIMING  = 2'd2,
      ST_COMMIT  = 2'd3
   } ctl_state_e;
endpackage

// File: rtl/pgm_word_buf.sv
module pgm_word_buf #(
   parameter int DATA_W     = 16,
   parameter int PAGE_WORDS = 4,
   parameter int CNT_W      = $clog2(PAGE_WORDS + 1),
   parameter int IDX_W      = $clog2(PAGE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_hit,
   input  logic [CNT_W-1:0]  limit,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CNT_W-1:0]  count,
   output logic              reject,
   output logic [DATA_W-1:0] rd_data
);
   logic              take;
   logic [DATA_W-1:0] slot_q [PAGE_WORDS];

   assign take = push && !clear && (count < limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         reject <= 1'b0;
      end else if (clear) begin
         count  <= '0;
         reject <= 1'b0;
      end else if (take) begin
         count  <= count + 1'b1;
         reject <= reject | push_hit;
      end
   end

   for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[i] <= '0;
         else if (take && count == CNT_W'(i))
            slot_q[i] <= push_data;
      end
   end

   assign rd_data = slot_q[rd_idx];

   // R6: a word arriving once the kind's limit is reached leaves the count unchanged
   p_full_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clear && count >= limit) |=> $stable(count));
endmodule

// File: rtl/pgm_cycle_timer.sv
module pgm_cycle_timer #(
   parameter int CYC_LEN = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic running,
   output logic expire
);
   localparam int TM_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;

   if (CYC_LEN == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     running <= 1'b0;
         else if (start) running <= 1'b1;
         else if (expire) running <= 1'b0;
      end
      assign expire = running;
   end else begin : g_cnt
      logic [TM_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            running <= 1'b0;
            cnt_q   <= '0;
         end else if (start) begin
            running <= 1'b1;
            cnt_q   <= '0;
         end else if (running) begin
            if (cnt_q == TM_W'(CYC_LEN - 1)) begin
               running <= 1'b0;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
      assign expire = running && (cnt_q == TM_W'(CYC_LEN - 1));
   end

   // R5: one expiry per started cycle
   p_expire_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !start) |=> !expire);
endmodule

// File: rtl/pgm_addr_gen.sv
module pgm_addr_gen #(
   parameter int ADDR_W = 8,
   parameter int PG_W   = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] idx,
   input  logic              fill,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] paged;
   logic [PG_W-1:0]   low_sum;

   // only the in-page bits advance; a carry out of them is discarded
   assign low_sum = base[PG_W-1:0] + idx[PG_W-1:0];
   assign paged   = {base[ADDR_W-1:PG_W], low_sum};
   assign addr    = fill ? idx : paged;
endmodule

// File: rtl/pgm_cycle_ctrl.sv
module pgm_cycle_ctrl
   import pgm_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 16,
   parameter int PAGE_WORDS = 4,
   parameter int CYC_LEN    = 50000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_open,
   input  logic [1:0]        cmd_kind,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              word_vld,
   input  logic [DATA_W-1:0] word_data,
   input  logic              cs_fall,
   input  logic              cs_fall_aligned,
   output logic [ADDR_W-1:0] chk_addr,
   input  logic              chk_hit,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic              done
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PG_W  = $clog2(PAGE_WORDS);
   localparam int CNT_W = $clog2(PAGE_WORDS + 1);

   initial begin
      a_page_pow2: assert (PAGE_WORDS >= 2 && (PAGE_WORDS & (PAGE_WORDS - 1)) == 0)
         else $error("PAGE_WORDS must be a power of two of at least 2");
      a_addr_wide: assert (ADDR_W > PG_W)
         else $error("ADDR_W must exceed the page index width");
      a_cyc_len: assert (CYC_LEN >= 1)
         else $error("CYC_LEN must be at least 1");
      a_data_w: assert (DATA_W >= 1)
         else $error("DATA_W must be at least 1");
   end

   ctl_state_e        st_q;
   wr_kind_e          kind_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] cidx_q;
   logic              done_q;

   logic              in_idle, in_collect, in_timing, in_commit;
   logic              is_fill, open_ok, push, fire, drop, last_commit;
   logic              expire, tmr_running;
   logic [CNT_W-1:0]  limit, wcount;
   logic              rej;
   logic [PG_W-1:0]   rd_idx;
   logic [DATA_W-1:0] rd_data;

   assign in_idle    = (st_q == ST_IDLE);
   assign in_collect = (st_q == ST_COLLECT);
   assign in_timing  = (st_q == ST_TIMING);
   assign in_commit  = (st_q == ST_COMMIT);
   assign is_fill    = (kind_q == WK_FILL);

   assign limit   = (kind_q == WK_PAGE) ? CNT_W'(PAGE_WORDS) : CNT_W'(1);
   assign open_ok = cmd_open && (in_idle || in_collect) && (cmd_kind != 2'd3);
   assign push    = in_collect && word_vld;
   assign fire    = in_collect && !open_ok && cs_fall && cs_fall_aligned
                    && (wcount != '0) && !rej;
   assign drop    = in_collect && !open_ok && cs_fall && !fire;

   assign last_commit = is_fill ? (cidx_q == ADDR_W'(DEPTH - 1))
                                : (cidx_q == ADDR_W'(wcount) - 1'b1);
   assign rd_idx      = is_fill ? '0 : cidx_q[PG_W-1:0];

   pgm_word_buf #(
      .DATA_W    (DATA_W),
      .PAGE_WORDS(PAGE_WORDS),
      .CNT_W     (CNT_W),
      .IDX_W     (PG_W)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (open_ok),
      .push     (push),
      .push_data(word_data),
      .push_hit (chk_hit),
      .limit    (limit),
      .rd_idx   (rd_idx),
      .count    (wcount),
      .reject   (rej),
      .rd_data  (rd_data)
   );

   pgm_cycle_timer #(.CYC_LEN(CYC_LEN)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (fire),
      .running(tmr_running),
      .expire (expire)
   );

   pgm_addr_gen #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_qaddr (
      .base(base_q),
      .idx (ADDR_W'(wcount)),
      .fill(is_fill),
      .addr(chk_addr)
   );

   pgm_addr_gen #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_caddr (
      .base(base_q),
      .idx (cidx_q),
      .fill(is_fill),
      .addr(arr_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= WK_SINGLE;
         base_q <= '0;
         cidx_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= in_commit && last_commit;
         unique case (st_q)
            ST_IDLE, ST_COLLECT: begin
               if (open_ok) begin
                  st_q   <= ST_COLLECT;
                  kind_q <= wr_kind_e'(cmd_kind);
                  base_q <= cmd_addr;
               end else if (fire) begin
                  st_q <= ST_TIMING;
               end else if (drop) begin
                  st_q <= ST_IDLE;
               end
            end
            ST_TIMING: begin
               if (expire) begin
                  st_q   <= ST_COMMIT;
                  cidx_q <= '0;
               end
            end
            ST_COMMIT: begin
               cidx_q <= cidx_q + 1'b1;
               if (last_commit) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = in_timing || in_commit;
   assign arr_we    = in_commit;
   assign arr_wdata = rd_data;
   assign done      = done_q;

   // R2: busy only ever begins after an aligned chip-select drop
   p_start_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_fall && cs_fall_aligned));

   // R3: a flagged command never enters the programming cycle
   p_reject_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_collect && rej && cs_fall && !cmd_open) |=> !busy);

   // R1: page writes keep the upper address bits of the start address
   p_page_hi_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && !is_fill) |-> (arr_addr[ADDR_W-1:PG_W] == base_q[ADDR_W-1:PG_W]));

   // R4: the fill value does not change across the sweep
   p_fill_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && is_fill && $past(arr_we)) |-> $stable(arr_wdata));

   // R8: done directly follows a write strobe
   p_done_after_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(arr_we));

   // R9: once busy, only the final commit ends it
   p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(in_commit && last_commit)) |=> busy);

   // R5: the timer runs only while the controller waits out the cycle
   p_timer_in_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_running |-> in_timing);
endmodule

// File: tb/pgm_cycle_ctrl_tb.sv
module pgm_cycle_ctrl_tb;
   localparam int CLK_P  = 10;
   localparam int AW     = 4;
   localparam int DW     = 8;
   localparam int PW     = 4;
   localparam int CL     = 6;
   localparam int DEPTH  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_open = 1'b0;
   logic [1:0]    cmd_kind = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic          word_vld = 1'b0;
   logic [DW-1:0] word_data = '0;
   logic          cs_fall = 1'b0;
   logic          cs_fall_aligned = 1'b0;
   logic [AW-1:0] chk_addr;
   logic          chk_hit;
   logic          busy, arr_we, done;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_wdata;

   int prot_lim = DEPTH;
   int cur_kind = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] exp_mem [DEPTH];
   int log_a [64];
   int log_d [64];
   int log_n = 0;
   int busy_cyc = 0;
   int done_cnt = 0;

   always #(CLK_P/2) clk = ~clk;

   // protection model of the surrounding logic
   assign chk_hit = (cur_kind == 2) ? (prot_lim < DEPTH) : (int'(chk_addr) >= prot_lim);

   pgm_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(PW), .CYC_LEN(CL)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_open(cmd_open), .cmd_kind(cmd_kind),
      .cmd_addr(cmd_addr), .word_vld(word_vld), .word_data(word_data),
      .cs_fall(cs_fall), .cs_fall_aligned(cs_fall_aligned), .chk_addr(chk_addr),
      .chk_hit(chk_hit), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .done(done)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) busy_cyc++;
         if (done) done_cnt++;
         if (arr_we) begin
            mem[arr_addr] = arr_wdata;
            if (log_n < 64) begin
               log_a[log_n] = int'(arr_addr);
               log_d[log_n] = int'(arr_wdata);
            end
            log_n++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int dval(input int s, input int k);
      return (s * 7 + k * 29 + 3) & 8'hFF;
   endfunction

   function automatic int pa(input int b, input int k);
      return (b & (DEPTH - PW)) | ((b + k) & (PW - 1));
   endfunction

   task automatic t_open(input int kind, input int addr);
      @(negedge clk);
      cmd_open = 1'b1; cmd_kind = 2'(kind); cmd_addr = AW'(addr);
      @(negedge clk);
      cmd_open = 1'b0;
   endtask

   task automatic t_words(input int nw, input int seed);
      for (int k = 0; k < nw; k++) begin
         word_vld = 1'b1; word_data = DW'(dval(seed, k));
         @(negedge clk);
         word_vld = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic t_fall(input bit align);
      cs_fall = 1'b1; cs_fall_aligned = align;
      @(negedge clk);
      cs_fall = 1'b0; cs_fall_aligned = 1'b0;
   endtask

   task automatic clr_logs();
      log_n = 0; busy_cyc = 0; done_cnt = 0;
   endtask

   task automatic mem_cmp(input string req);
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] !== exp_mem[i]) bad++;
      chk(bad == 0, req, bad, 0);
   endtask

   task automatic run_case(input int kind, input int addr, input int nw, input int seed,
                           input bit align, input int lim, input string req);
      int nmax, nacc, ncom, ea, ed;
      bit rej, ok;
      prot_lim = lim; cur_kind = kind;
      clr_logs();
      t_open(kind, addr);
      t_words(nw, seed);
      t_fall(align);
      repeat (CL + DEPTH + 6) @(negedge clk);
      nmax = (kind == 1) ? PW : 1;
      nacc = (nw < nmax) ? nw : nmax;
      rej = 0;
      for (int k = 0; k < nacc; k++) begin
         if (kind == 2) rej |= (lim < DEPTH);
         else if (pa(addr, k) >= lim) rej = 1;
      end
      ok = (kind != 3) && align && (nacc > 0) && !rej;
      ncom = ok ? ((kind == 2) ? DEPTH : nacc) : 0;
      chk(busy_cyc == (ok ? CL + ncom : 0), {"R5 busy span ", req}, busy_cyc, ok ? CL + ncom : 0);
      chk(log_n == ncom, {"writes ", req}, log_n, ncom);
      chk(done_cnt == (ok ? 1 : 0), {"R8 done ", req}, done_cnt, ok ? 1 : 0);
      for (int i = 0; i < ncom && i < log_n; i++) begin
         ea = (kind == 2) ? i : pa(addr, i);
         ed = dval(seed, (kind == 2) ? 0 : i);
         chk(log_a[i] == ea, {"R7 order/addr ", req}, log_a[i], ea);
         chk(log_d[i] == ed, {"R7 order/data ", req}, log_d[i], ed);
         exp_mem[ea] = DW'(ed);
      end
      mem_cmp({"array ", req});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int seed = 1;
      for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; exp_mem[i] = '0; end
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(busy == 1'b0, "R10 busy", int'(busy), 0);
      chk(arr_we == 1'b0, "R10 arr_we", int'(arr_we), 0);
      chk(done == 1'b0, "R10 done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R10 busy after release", int'(busy), 0);

      // R1 R3: page sweep over start address, word count and protection limit
      for (int li = 0; li < 3; li++) begin
         int lim = (li == 0) ? DEPTH : (li == 1) ? 12 : 5;
         for (int b = 0; b < DEPTH; b++)
            for (int n = 1; n <= PW; n++) begin
               run_case(1, b, n, seed, 1'b1, lim, "R1 R3 page");
               seed++;
            end
      end

      // R6: extra page words ignored
      for (int b = 0; b < 4; b++) begin
         run_case(1, b * 5, PW + 2, seed, 1'b1, DEPTH, "R6 page overflow");
         seed++;
      end

      // R3: single writes against a limit
      for (int a = 0; a < DEPTH; a++) begin
         run_case(0, a, 1, seed, 1'b1, 8, "R3 single");
         seed++;
      end

      // R6: single write with surplus words, and the ignored kind code 3
      run_case(0, 3, 3, seed++, 1'b1, DEPTH, "R6 single surplus");
      run_case(3, 6, 1, seed++, 1'b1, DEPTH, "R6 kind3");

      // R2: misaligned drop and drop with no word
      run_case(1, 8, 2, seed++, 1'b0, DEPTH, "R2 misaligned");
      run_case(0, 2, 0, seed++, 1'b1, DEPTH, "R2 no word");
      run_case(1, 1, 0, seed++, 1'b1, DEPTH, "R2 page no word");

      // R4: fill accepted, then rejected under protection
      run_case(2, 9, 1, seed++, 1'b1, DEPTH, "R4 fill");
      run_case(2, 0, 1, seed++, 1'b1, 10, "R4 R3 fill protected");

      // R9: a full command issued while busy is ignored
      prot_lim = DEPTH; cur_kind = 1;
      clr_logs();
      t_open(1, 4);
      t_words(2, 200);
      t_fall(1'b1);
      t_open(0, 9);
      t_words(1, 201);
      t_fall(1'b1);
      repeat (CL + DEPTH + 6) @(negedge clk);
      chk(busy_cyc == CL + 2, "R9 busy span", busy_cyc, CL + 2);
      chk(log_n == 2, "R9 write count", log_n, 2);
      exp_mem[4] = DW'(dval(200, 0));
      exp_mem[5] = DW'(dval(200, 1));
      mem_cmp("R9 array");

      // R11: reopening during collection discards earlier words
      clr_logs();
      t_open(1, 12);
      t_words(2, 210);
      cur_kind = 0;
      t_open(0, 9);
      t_words(1, 211);
      t_fall(1'b1);
      repeat (CL + DEPTH + 6) @(negedge clk);
      chk(log_n == 1, "R11 write count", log_n, 1);
      chk(busy_cyc == CL + 1, "R11 busy span", busy_cyc, CL + 1);
      exp_mem[9] = DW'(dval(211, 0));
      mem_cmp("R11 array");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule